// File: doc/BRIEF.md
# Eight-Channel ISA-Style DMA Address Engine

This block generates the physical addresses for eight DMA channels that behave like the classic ISA DMA controller. Each channel holds a 16-bit current address, an 8-bit page and a 16-bit transfer count. Channels 0 to 3 move bytes. Channels 5 to 7 move 16-bit words, and their address is shifted up by one bit. Channel 4 is kept as a reserved bus-master slot and never produces a transfer. Software programs each channel through a plain write port that uses a select code. A peripheral raises its request line. The engine picks the lowest-numbered unmasked requester and raises that channel's acknowledge. It then presents one transfer descriptor per beat on a valid/ready output.

A descriptor carries the 24-bit address, the channel, the width, whether a read/write strobe is wanted (it is not wanted in verify mode) and whether this beat is the terminal count. The descriptor stays on the output until `xfer_ready` is sampled high. A beat counts as accepted on the rising edge where `xfer_valid` and `xfer_ready` are both high. Only an accepted beat advances the channel's address and count. Back-pressure has no limit: the engine holds the beat, the acknowledge and all channel state for as long as ready stays low. The page never changes on its own. When the low address wraps, the transfer stays inside the same 64 KB (byte channels) or 128 KB (word channels) window.

Top module: `dma_isa_engine`

## Requirements
- R1: After reset every channel is masked (`mask_flags` = 8'hFF), `tc_flags` = 0, `dack` = 0 and `xfer_valid` = 0.
- R2: A write with `cfg_we` high loads the register of channel `cfg_ch` picked by `cfg_sel`. Code 0 loads the current address from `cfg_wdata[15:0]`. Code 1 loads the page from `cfg_wdata[7:0]`. Code 2 loads the count from `cfg_wdata[15:0]`. Code 3 loads the control word: bit 0 selects demand mode (0 selects single), bit 1 selects verify, and bit 2 sets the mask. A control write also clears that channel's terminal-count flag.
- R3: Channels 0 to 3 give `xfer_wide` = 0 and address {page[7:0], current[15:0]}.
- R4: Channels 5 to 7 give `xfer_wide` = 1 and address {page[7:1], current[15:0], 1'b0}, so bit 0 is always 0.
- R5: Channel 4 is never acknowledged and never produces a beat, even after a control write that clears its mask. Its bit in `mask_flags` reads 1 at all times.
- R6: Each accepted beat increments the current address by one, wrapping modulo 2^16, and leaves the page unchanged.
- R7: Each accepted beat decrements the count. The beat taken while the count is 0 is flagged with `xfer_tc` = 1, which means a loaded count N yields N+1 beats. After that beat the channel's bits in `tc_flags` and `mask_flags` are set and its acknowledge drops.
- R8: In single mode the acknowledge drops after every accepted beat. Arbitration then runs again, one idle cycle later.
- R9: In demand mode the acknowledge and `xfer_valid` stay up for the next beat if the channel's request is still high on the accepting edge. Otherwise the engine releases the channel, and it also releases the channel at terminal count.
- R10: In verify mode `xfer_strobe` is 0. Address and count still advance as in R6 and R7.
- R11: Among simultaneous requests, the lowest-numbered unmasked channel wins. Masked channels are ignored.
- R12: While `xfer_valid` is high and `xfer_ready` is low, the address, channel and `dack` hold steady and no channel state changes.
- R13: A request seen on an idle edge raises `dack` and `xfer_valid` for that channel in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 3 | Channel addressed by the write |
| cfg_sel | input | 2 | Register select: 0 address, 1 page, 2 count, 3 control |
| cfg_wdata | input | 16 | Write data |
| dreq | input | 8 | Per-channel transfer request |
| dack | output | 8 | Per-channel acknowledge, at most one high |
| xfer_valid | output | 1 | Transfer descriptor valid |
| xfer_ready | input | 1 | Descriptor accepted when high with valid |
| xfer_addr | output | 24 | Physical address of the beat |
| xfer_ch | output | 3 | Channel owning the beat |
| xfer_wide | output | 1 | 1 for a 16-bit beat, 0 for an 8-bit beat |
| xfer_strobe | output | 1 | 1 when a read/write strobe is wanted (not verify) |
| xfer_tc | output | 1 | Beat is the terminal count of its channel |
| tc_flags | output | 8 | Per-channel terminal-count status |
| mask_flags | output | 8 | Per-channel mask state |

## Verification
The bench builds the engine with its default parameters: eight channels, 16-bit address and count words, an 8-bit page, and channel 4 as the reserved slot. With these values both address forms can be reached, including the word form that drops page bit 0 and shifts the low word up. Start values of 0xFFFE and 0xFFFF in the current address make the 16-bit wrap occur within two or three beats. Small counts bring terminal count, the masking that follows it, and demand-mode release within a few cycles.

// File: rtl/dma_isa_pkg.sv
package dma_isa_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_PAGE  = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_CTRL  = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic verify;
    logic demand;
  } chan_mode_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } eng_state_e;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_isa_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int PAGE_W     = 8,
  parameter bit FORCE_MASK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              step,
  output logic [WORD_W-1:0] cur_addr,
  output logic [PAGE_W-1:0] page,
  output chan_mode_t        mode,
  output logic              masked,
  output logic              tc_flag,
  output logic              cnt_zero
);

  logic [WORD_W-1:0] count_q;

  assign cnt_zero = (count_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      page     <= '0;
      count_q  <= '0;
      mode     <= '0;
      masked   <= 1'b1;
      tc_flag  <= 1'b0;
    end else if (wr_en) begin
      unique case (cfg_sel_e'(wr_sel))
        SEL_ADDR:  cur_addr <= wr_data;
        SEL_PAGE:  page     <= wr_data[PAGE_W-1:0];
        SEL_COUNT: count_q  <= wr_data;
        SEL_CTRL: begin
          mode.demand <= wr_data[0];
          mode.verify <= wr_data[1];
          masked      <= FORCE_MASK ? 1'b1 : wr_data[2];
          tc_flag     <= 1'b0;
        end
        default: ;
      endcase
    end else if (step) begin
      // The low word wraps inside its window; the page is left alone.
      cur_addr <= cur_addr + 1'b1;
      count_q  <= count_q - 1'b1;
      if (cnt_zero) begin
        tc_flag <= 1'b1;
        masked  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req,
  output logic              any,
  output logic [CH_W-1:0]   win
);

  always_comb begin
    any = 1'b0;
    win = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req[i] && !any) begin
        any = 1'b1;
        win = CH_W'(i);
      end
    end
  end

endmodule

// File: rtl/dma_addr_form.sv
module dma_addr_form #(
  parameter int WORD_W  = 16,
  parameter int PAGE_W  = 8,
  localparam int PHYS_W = WORD_W + PAGE_W
) (
  input  logic [WORD_W-1:0] cur_addr,
  input  logic [PAGE_W-1:0] page,
  input  logic              wide,
  output logic [PHYS_W-1:0] phys
);

  logic [PHYS_W-1:0] narrow_addr;
  logic [PHYS_W-1:0] wide_addr;

  assign narrow_addr = {page, cur_addr};
  assign wide_addr   = {page[PAGE_W-1:1], cur_addr, 1'b0};
  assign phys        = wide ? wide_addr : narrow_addr;

endmodule

// File: rtl/dma_isa_engine.sv
module dma_isa_engine
  import dma_isa_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int WORD_W  = 16,
  parameter int PAGE_W  = 8,
  parameter int RSV_CH  = 4,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int PHYS_W = WORD_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [1:0]        cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic [NUM_CH-1:0] dreq,
  output logic [NUM_CH-1:0] dack,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [PHYS_W-1:0] xfer_addr,
  output logic [CH_W-1:0]   xfer_ch,
  output logic              xfer_wide,
  output logic              xfer_strobe,
  output logic              xfer_tc,
  output logic [NUM_CH-1:0] tc_flags,
  output logic [NUM_CH-1:0] mask_flags
);

  logic [WORD_W-1:0] cur_a  [NUM_CH];
  logic [PAGE_W-1:0] page_a [NUM_CH];
  chan_mode_t        mode_a [NUM_CH];
  logic [NUM_CH-1:0] cnt_zero;
  logic [NUM_CH-1:0] step;
  logic [NUM_CH-1:0] eligible;

  eng_state_e      state_q;
  logic [CH_W-1:0] act_q;
  logic            arb_any;
  logic [CH_W-1:0] arb_win;
  logic            accept;
  logic            keep;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dma_chan_regs #(
      .WORD_W    (WORD_W),
      .PAGE_W    (PAGE_W),
      .FORCE_MASK(g == RSV_CH)
    ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we && (cfg_ch == CH_W'(g))),
      .wr_sel  (cfg_sel),
      .wr_data (cfg_wdata),
      .step    (step[g]),
      .cur_addr(cur_a[g]),
      .page    (page_a[g]),
      .mode    (mode_a[g]),
      .masked  (mask_flags[g]),
      .tc_flag (tc_flags[g]),
      .cnt_zero(cnt_zero[g])
    );
    assign step[g]     = accept && (act_q == CH_W'(g));
    assign eligible[g] = dreq[g] && !mask_flags[g] && (g != RSV_CH);
  end

  dma_prio_arb #(.NUM_CH(NUM_CH)) u_arb (
    .req(eligible),
    .any(arb_any),
    .win(arb_win)
  );

  assign xfer_valid = (state_q == ST_XFER);
  assign accept     = xfer_valid && xfer_ready;
  assign keep       = mode_a[act_q].demand && !cnt_zero[act_q] && dreq[act_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      act_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (arb_any) begin
          state_q <= ST_XFER;
          act_q   <= arb_win;
        end
        ST_XFER: if (accept && !keep) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    dack = '0;
    if (xfer_valid) dack[act_q] = 1'b1;
  end

  assign xfer_ch     = act_q;
  assign xfer_wide   = (int'(act_q) > RSV_CH);
  assign xfer_strobe = !mode_a[act_q].verify;
  assign xfer_tc     = cnt_zero[act_q];

  dma_addr_form #(.WORD_W(WORD_W), .PAGE_W(PAGE_W)) u_form (
    .cur_addr(cur_a[act_q]),
    .page    (page_a[act_q]),
    .wide    (xfer_wide),
    .phys    (xfer_addr)
  );

endmodule

// File: rtl/dma_isa_engine_chk.sv
module dma_isa_engine_chk #(
  parameter int NUM_CH  = 8,
  parameter int RSV_CH  = 4,
  parameter int CH_W    = 3,
  parameter int PHYS_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] dack,
  input logic              xfer_valid,
  input logic              xfer_ready,
  input logic [PHYS_W-1:0] xfer_addr,
  input logic [CH_W-1:0]   xfer_ch,
  input logic              xfer_wide,
  input logic              xfer_tc,
  input logic [NUM_CH-1:0] tc_flags,
  input logic [NUM_CH-1:0] mask_flags
);

  a_r5_no_rsv_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !dack[RSV_CH]);

  a_r11_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  a_r13_ack_matches_beat: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> dack[xfer_ch]);

  a_r4_wide_even: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_wide) |-> !xfer_addr[0]);

  a_r3_width_by_channel: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (xfer_wide == (int'(xfer_ch) > RSV_CH)));

  a_r12_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=>
      (xfer_valid && $stable(xfer_addr) && $stable(xfer_ch) && $stable(dack)));

  a_r7_tc_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready && xfer_tc) |=> (dack == '0));

  a_r7_tc_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_ready && xfer_tc) |=>
      (tc_flags[$past(xfer_ch)] && mask_flags[$past(xfer_ch)]));

endmodule

bind dma_isa_engine dma_isa_engine_chk #(
  .NUM_CH(NUM_CH),
  .RSV_CH(RSV_CH),
  .CH_W  (CH_W),
  .PHYS_W(PHYS_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dack      (dack),
  .xfer_valid(xfer_valid),
  .xfer_ready(xfer_ready),
  .xfer_addr (xfer_addr),
  .xfer_ch   (xfer_ch),
  .xfer_wide (xfer_wide),
  .xfer_tc   (xfer_tc),
  .tc_flags  (tc_flags),
  .mask_flags(mask_flags)
);

// File: tb/dma_isa_engine_test.sv
module dma_isa_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_ch = '0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic [7:0]  dreq = '0;
  logic [7:0]  dack;
  logic        xfer_valid;
  logic        xfer_ready = 1'b0;
  logic [23:0] xfer_addr;
  logic [2:0]  xfer_ch;
  logic        xfer_wide;
  logic        xfer_strobe;
  logic        xfer_tc;
  logic [7:0]  tc_flags;
  logic [7:0]  mask_flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dma_isa_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .dreq(dreq), .dack(dack),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
    .xfer_ch(xfer_ch), .xfer_wide(xfer_wide), .xfer_strobe(xfer_strobe),
    .xfer_tc(xfer_tc), .tc_flags(tc_flags), .mask_flags(mask_flags)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int sel, input logic [15:0] data);
    cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_sel = 2'(sel); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int ch, input logic [15:0] a, input logic [7:0] pg,
                       input logic [15:0] cnt, input logic [15:0] ctrl);
    wr(ch, 0, a);
    wr(ch, 1, {8'h00, pg});
    wr(ch, 2, cnt);
    wr(ch, 3, ctrl);
  endtask

  // Wait for a beat, compare it, then accept it. Returns at the negedge after acceptance.
  task automatic take(input int ch, input logic [23:0] addr, input bit wide,
                      input bit tc, input bit strobe, input string tag);
    bit seen = 1'b0;
    for (int k = 0; k < 20 && !seen; k++) begin
      if (xfer_valid) seen = 1'b1;
      else @(negedge clk);
    end
    chk(seen, {tag, " valid"}, 32'(xfer_valid), 32'd1);
    chk(xfer_ch == 3'(ch), {tag, " channel"}, 32'(xfer_ch), 32'(ch));
    chk(xfer_addr == addr, {tag, " address"}, 32'(xfer_addr), 32'(addr));
    chk(xfer_wide == wide, {tag, " width"}, 32'(xfer_wide), 32'(wide));
    chk(xfer_tc == tc, {tag, " tc"}, 32'(xfer_tc), 32'(tc));
    chk(xfer_strobe == strobe, {tag, " strobe"}, 32'(xfer_strobe), 32'(strobe));
    xfer_ready = 1'b1;
    @(negedge clk);
    xfer_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk(dack == 8'h00, "R1 dack", 32'(dack), 0);
    chk(!xfer_valid, "R1 valid", 32'(xfer_valid), 0);
    chk(tc_flags == 8'h00, "R1 tc_flags", 32'(tc_flags), 0);
    chk(mask_flags == 8'hFF, "R1 mask_flags", 32'(mask_flags), 32'hFF);
  endtask

  task automatic t_byte_single;
    setup(2, 16'hFFFE, 8'h12, 16'd2, 16'h0000);
    chk(mask_flags[2] == 1'b0, "R2 ctrl unmask", 32'(mask_flags), 32'hFB);
    dreq[2] = 1'b1;
    @(negedge clk);
    chk(xfer_valid && dack == 8'h04, "R13 grant next cycle", 32'(dack), 32'h04);
    take(2, 24'h12FFFE, 0, 0, 1, "R3 byte beat 1");
    chk(dack == 8'h00 && !xfer_valid, "R8 single release", 32'(dack), 0);
    @(negedge clk);
    chk(dack == 8'h04, "R8 rearbitrate", 32'(dack), 32'h04);
    take(2, 24'h12FFFF, 0, 0, 1, "R6 byte beat 2");
    take(2, 24'h120000, 0, 1, 1, "R6 wrap page kept R7 tc");
    chk(tc_flags[2] && mask_flags[2], "R7 flags set", 32'({tc_flags[2], mask_flags[2]}), 32'd3);
    repeat (3) @(negedge clk);
    chk(dack == 8'h00 && !xfer_valid, "R7 masked after tc", 32'(dack), 0);
    dreq[2] = 1'b0;
    wr(2, 3, 16'h0000);
    chk(!tc_flags[2] && !mask_flags[2], "R2 ctrl clears tc", 32'({tc_flags[2], mask_flags[2]}), 0);
    wr(2, 3, 16'h0004);
  endtask

  task automatic t_verify;
    setup(1, 16'h00FF, 8'h07, 16'd1, 16'h0002);
    dreq[1] = 1'b1;
    take(1, 24'h0700FF, 0, 0, 0, "R10 verify beat 1");
    take(1, 24'h070100, 0, 1, 0, "R10 verify beat 2");
    chk(tc_flags[1] == 1'b1, "R10 verify reaches tc", 32'(tc_flags), 32'h02);
  endtask

  task automatic t_priority;
    setup(0, 16'h1000, 8'h00, 16'd10, 16'h0000);
    setup(3, 16'h0042, 8'hAB, 16'd10, 16'h0000);
    dreq[0] = 1'b1; dreq[3] = 1'b1;
    take(0, 24'h001000, 0, 0, 1, "R11 lowest wins");
    take(0, 24'h001001, 0, 0, 1, "R11 lowest again");
    dreq[0] = 1'b0;
    take(3, 24'hAB0042, 0, 0, 1, "R11 masked ch1 skipped");
    dreq = '0;
    @(negedge clk);
  endtask

  task automatic t_reserved;
    wr(4, 3, 16'h0000);
    dreq = 8'h10;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(dack == 8'h00 && !xfer_valid, "R5 reserved idle", 32'(dack), 0);
    end
    chk(mask_flags[4] == 1'b1, "R5 reserved mask", 32'(mask_flags), 32'h10);
    dreq = '0;
  endtask

  task automatic t_stall;
    logic [23:0] held;
    setup(5, 16'h0003, 8'h01, 16'd0, 16'h0000);
    dreq[5] = 1'b1;
    @(negedge clk);
    held = xfer_addr;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(xfer_valid && dack == 8'h20 && xfer_addr == held, "R12 hold on stall",
          32'(xfer_addr), 32'(held));
    end
    take(5, 24'h000006, 1, 1, 1, "R4 word beat after stall");
    dreq[5] = 1'b0;
  endtask

  task automatic t_demand;
    setup(6, 16'hFFFF, 8'h35, 16'd1, 16'h0001);
    dreq[6] = 1'b1;
    take(6, 24'h35FFFE, 1, 0, 1, "R4 word address");
    chk(dack == 8'h40 && xfer_valid, "R9 demand holds ack", 32'(dack), 32'h40);
    take(6, 24'h340000, 1, 1, 1, "R6 word wrap page kept");
    chk(dack == 8'h00, "R9 demand ends at tc", 32'(dack), 0);
    dreq[6] = 1'b0;
    setup(7, 16'h0010, 8'h02, 16'd5, 16'h0001);
    dreq[7] = 1'b1;
    take(7, 24'h020020, 1, 0, 1, "R9 demand beat 1");
    dreq[7] = 1'b0;
    take(7, 24'h020022, 1, 0, 1, "R9 demand beat 2");
    chk(dack == 8'h00 && !tc_flags[7], "R9 release on dropped request", 32'(dack), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_single();
    t_verify();
    t_priority();
    t_reserved();
    t_stall();
    t_demand();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule